// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the byte-wide register face of a classic serial port. A host reaches it over a small memory-mapped bus: a 3-bit offset, one-cycle read and write strobes, and 8-bit data. On the device side it takes bytes from a receive source, which shows a data-available flag and the byte at its head and is popped by a strobe. It pushes written bytes into a transmit sink. It keeps the interrupt-enable, line-control and modem-control values. It derives the interrupt identity and line status values from its own state. It drives a single level interrupt.

The receive and transmit interrupt sources are not posted at once. Each one arms a delay timer of `DELAY_CYCLES` clock cycles. Arming it again while it runs reloads the full interval. When the timer runs out, the source is posted only if its enable bit is still set. A transmit interrupt may bypass the timer when the host enables it, but only if the last transmit interrupt was posted more than one interval earlier. This delay keeps a fast stream of input from holding a driver inside its service loop. Serial bit timing, the baud divisor, FIFOs and modem pins are not part of this block.

Top module: `uart_regfront`

## Requirements
- R1: After a synchronous reset the stored registers and both interrupt status bits are zero and no timer runs. `irq` and `bus_rdata` are 0, an identity read returns 0x01, and the transmit age is saturated, so it counts as older than one interval.
- R2: Bus reads and writes act at the clock edge where their strobe is high. A read returns its value on `bus_rdata` after that edge, and `bus_rdata` holds that value until the next read. Offset 3 reads back the line-control value that was written. Offset 5 reads 0x60 plus bit 0 set when `rx_avail` is high. Offsets 6 and 7 read 0. Writes to offsets 2 and 7 change nothing.
- R3: While line-control bit 7 is set, offsets 0 and 1 read 0. A write at either offset pushes nothing and leaves the enable value unchanged, and a read at either offset pops nothing.
- R4: A read at offset 0 returns `rx_byte` and pulses `rx_pop` when `rx_avail` is high, and otherwise returns 0 without a pop. It clears receive status. If enable bit 0 is set, it restarts the receive timer.
- R5: A write at offset 0 raises `tx_push` for one cycle after the edge, with `tx_byte` carrying the written byte. It clears transmit status. If enable bit 1 is set, it starts the transmit timer.
- R6: A started timer expires exactly `DELAY_CYCLES` edges after the edge that started it. A new start while the timer runs reloads the full interval.
- R7: On expiry, transmit status is set only if enable bit 1 is set. Receive status is set only if enable bit 0 is set and `rx_avail` is high.
- R8: An identity read (offset 2) returns 0x04 when receive status is set, and then leaves both status bits as they were. Otherwise it returns 0x02 and clears transmit status when transmit status is set. Otherwise it returns 0x01.
- R9: A write at offset 1 with bit 1 set posts transmit status at that edge when more than `DELAY_CYCLES` edges have passed since the last transmit post. Otherwise it starts the transmit timer.
- R10: A write at offset 1 with bit 1 clear cancels the transmit timer and clears transmit status. The same write with bit 0 clear, or with `rx_avail` low, cancels the receive timer and clears receive status. A write with bit 0 set while `rx_avail` is high starts the receive timer.
- R11: When `rx_avail` rises while enable bit 0 is set, the receive timer starts.
- R12: A write of exactly 0x1A at offset 4 makes offset 4 read 0x9A. Any other write there leaves the stored value unchanged.
- R13: `irq` is high exactly when receive or transmit status is set, and it changes only at clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, held between reads |
| rx_avail | input | 1 | Receive source has a byte |
| rx_byte | input | 8 | Byte at the head of the receive source |
| rx_pop | output | 1 | Pops the receive source at this edge |
| tx_push | output | 1 | Registered push strobe to the transmit sink |
| tx_byte | output | 8 | Byte being pushed |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus never raises read and write in the same cycle. They also assume that the receive source holds `rx_avail` and `rx_byte` steady between edges and changes them only after a pop or a new arrival. The bench keeps to both assumptions: each access is driven by a task that raises exactly one strobe for one cycle. The bench models the receive source as a queue that is updated only on falling edges. The stimulus also avoids a timer start and a cancel landing on the same edge, because that ordering is a choice of this design rather than a requirement.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_IDT  = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTS = 3'd5;
  localparam logic [2:0] OFS_MSTS = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int NSRC   = 2;

  localparam int BIT_BANK = 7;

  localparam logic [7:0] ID_RX     = 8'h04;
  localparam logic [7:0] ID_TX     = 8'h02;
  localparam logic [7:0] ID_NONE   = 8'h01;
  localparam logic [7:0] LSTS_BASE = 8'h60;
  localparam logic [7:0] MCTL_KEY  = 8'h1A;
  localparam logic [7:0] MCTL_VAL  = 8'h9A;
endpackage

// File: rtl/urf_delay_timer.sv
module urf_delay_timer #(
  parameter int INTERVAL = 11250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic expire
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LOAD = CW'(INTERVAL);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (start) begin
      count <= LOAD;
    end else if (cancel) begin
      count <= '0;
    end else if (count != '0) begin
      count <= count - ONE;
    end
  end

  assign expire = (count == ONE);

  // R6: an idle timer stays silent unless started
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !start) |=> !expire);
  // R10: a cancel without a start leaves no expiry behind
  p_cancel_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (cancel && !start) |=> !expire);
endmodule

// File: rtl/urf_age_counter.sv
module urf_age_counter #(
  parameter int LIMIT = 11250
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic older
);
  localparam int AW = $clog2(LIMIT + 2);
  localparam logic [AW-1:0] SAT = AW'(LIMIT + 1);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= SAT;
    end else if (clear) begin
      age <= AW'(1);
    end else if (age != SAT) begin
      age <= age + AW'(1);
    end
  end

  assign older = (age > LIM);

  // R9: just after a post the bypass is closed
  p_clear_closes_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> !older);
  // R1: the age never passes its saturation value
  p_age_bounded_r1: assert property (@(posedge clk) disable iff (rst)
    age <= SAT);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int DELAY_CYCLES = 11250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_avail,
  input  logic [7:0] rx_byte,
  output logic       rx_pop,
  output logic       tx_push,
  output logic [7:0] tx_byte,
  output logic       irq
);
  logic [7:0] ien_q, lctl_q, mctl_q;
  logic       rx_st, tx_st, avail_q;
  logic [NSRC-1:0] tmr_start, tmr_cancel, tmr_exp;
  logic       tx_older;

  logic bank, data_rd, data_wr, ien_wr, idt_rd, avail_rise;
  logic tx_now, rx_set, tx_set, tx_take, rx_nxt, tx_nxt;
  logic [7:0] rd_val;

  assign bank       = lctl_q[BIT_BANK];
  assign data_rd    = bus_rd && bus_addr == OFS_DATA && !bank;
  assign data_wr    = bus_wr && bus_addr == OFS_DATA && !bank;
  assign ien_wr     = bus_wr && bus_addr == OFS_IEN && !bank;
  assign idt_rd     = bus_rd && bus_addr == OFS_IDT;
  assign avail_rise = rx_avail && !avail_q;
  assign rx_pop     = data_rd && rx_avail;

  assign tx_now = ien_wr && bus_wdata[SRC_TX] && tx_older;

  assign tmr_start[SRC_RX]  = (data_rd && ien_q[SRC_RX])
                            || (ien_wr && bus_wdata[SRC_RX] && rx_avail)
                            || (avail_rise && ien_q[SRC_RX]);
  assign tmr_cancel[SRC_RX] = ien_wr && !(bus_wdata[SRC_RX] && rx_avail);
  assign tmr_start[SRC_TX]  = (data_wr && ien_q[SRC_TX])
                            || (ien_wr && bus_wdata[SRC_TX] && !tx_older);
  assign tmr_cancel[SRC_TX] = ien_wr && !bus_wdata[SRC_TX];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    urf_delay_timer #(.INTERVAL(DELAY_CYCLES)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .start  (tmr_start[s]),
      .cancel (tmr_cancel[s]),
      .expire (tmr_exp[s])
    );
  end

  assign rx_set  = tmr_exp[SRC_RX] && ien_q[SRC_RX] && rx_avail;
  assign tx_set  = tmr_exp[SRC_TX] && ien_q[SRC_TX];
  assign tx_take = idt_rd && !rx_st && tx_st;

  urf_age_counter #(.LIMIT(DELAY_CYCLES)) u_age (
    .clk   (clk),
    .rst   (rst),
    .clear (tx_set || tx_now),
    .older (tx_older)
  );

  assign rx_nxt = (rx_st || rx_set) && !data_rd && !tmr_cancel[SRC_RX];
  assign tx_nxt = ((tx_st || tx_set) && !data_wr && !tx_take
                   && !tmr_cancel[SRC_TX]) || tx_now;

  always_comb begin
    rd_val = 8'h00;
    case (bus_addr)
      OFS_DATA: rd_val = (!bank && rx_avail) ? rx_byte : 8'h00;
      OFS_IEN:  rd_val = bank ? 8'h00 : ien_q;
      OFS_IDT:  rd_val = rx_st ? ID_RX : (tx_st ? ID_TX : ID_NONE);
      OFS_LCTL: rd_val = lctl_q;
      OFS_MCTL: rd_val = mctl_q;
      OFS_LSTS: rd_val = LSTS_BASE | {7'd0, rx_avail};
      default:  rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      lctl_q    <= '0;
      mctl_q    <= '0;
      rx_st     <= 1'b0;
      tx_st     <= 1'b0;
      avail_q   <= 1'b0;
      bus_rdata <= '0;
      tx_push   <= 1'b0;
      tx_byte   <= '0;
    end else begin
      rx_st   <= rx_nxt;
      tx_st   <= tx_nxt;
      avail_q <= rx_avail;
      tx_push <= data_wr;
      if (data_wr) tx_byte <= bus_wdata;
      if (ien_wr) ien_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_LCTL) lctl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_MCTL && bus_wdata == MCTL_KEY) mctl_q <= MCTL_VAL;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign irq = rx_st || tx_st;

  // R2: bus rule taken for granted, one strobe at a time
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R2: status read always shows both transmitter bits
  p_lsts_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_LSTS) |=> bus_rdata[6:5] == 2'b11);
  // R3: banked data writes push nothing
  p_bank_no_push_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DATA && bank) |=> !tx_push);
  // R4: a data read leaves receive status clear
  p_rd_clears_rx_r4: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !rx_st);
  // R5: written byte reaches the sink on the next cycle
  p_wr_push_r5: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (tx_push && tx_byte == $past(bus_wdata)));
  // R7: transmit status only appears while enabled
  p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_st) |-> ien_q[SRC_TX]);
  // R8: identity read of a transmit source clears it
  p_idt_take_r8: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_st);
  // R10: disabling transmit drops its status
  p_ien_off_r10: assert property (@(posedge clk) disable iff (rst)
    (ien_wr && !bus_wdata[SRC_TX]) |=> !tx_st);
  // R12: only the key value moves the modem control value
  p_mctl_key_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_MCTL && bus_wdata != MCTL_KEY) |=> $stable(mctl_q));
endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rx_avail = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_pop, tx_push, irq;
  logic [7:0] tx_byte;

  uart_regfront #(.DELAY_CYCLES(N)) u_uart_regfront (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_avail(rx_avail),
    .rx_byte(rx_byte), .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte),
    .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;
  bit started = 0;

  byte unsigned rxq[$];

  // behavioural model state
  longint cyc = 0;
  longint rx_dl = -1, tx_dl = -1, last_tx = -1000000;
  byte unsigned m_ien = 0, m_lctl = 0, m_mctl = 0;
  bit m_rxs = 0, m_txs = 0, prev_avail = 0;
  byte unsigned e_rdata = 0, e_txb = 0;
  bit e_push = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_src();
    rx_avail = (rxq.size() > 0);
    rx_byte  = (rxq.size() > 0) ? rxq[0] : 8'h00;
  endtask

  always @(negedge clk) drive_src();

  task automatic push_rx(byte unsigned b);
    rxq.push_back(b);
    drive_src();
  endtask

  always @(posedge clk) begin
    if (rst) begin
      rx_dl = -1; tx_dl = -1; last_tx = -1000000;
      m_ien = 0; m_lctl = 0; m_mctl = 0; m_rxs = 0; m_txs = 0;
      prev_avail = 0; e_rdata = 0; e_txb = 0; e_push = 0;
    end else begin
      bit pre_rx, pre_tx, bank;
      pre_rx = m_rxs; pre_tx = m_txs;
      bank = m_lctl[7];
      e_push = 0;
      if (rx_dl == cyc) begin
        rx_dl = -1;
        if (m_ien[0] && rx_avail) m_rxs = 1;
      end
      if (tx_dl == cyc) begin
        tx_dl = -1;
        if (m_ien[1]) begin m_txs = 1; last_tx = cyc; end
      end
      if (rx_avail && !prev_avail && m_ien[0]) rx_dl = cyc + N;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: if (!bank) begin
            e_push = 1; e_txb = bus_wdata; m_txs = 0;
            if (m_ien[1]) tx_dl = cyc + N;
          end
          3'd1: if (!bank) begin
            m_ien = bus_wdata;
            if (bus_wdata[1]) begin
              if (cyc - last_tx > N) begin m_txs = 1; last_tx = cyc; end
              else tx_dl = cyc + N;
            end else begin tx_dl = -1; m_txs = 0; end
            if (bus_wdata[0] && rx_avail) rx_dl = cyc + N;
            else begin rx_dl = -1; m_rxs = 0; end
          end
          3'd3: m_lctl = bus_wdata;
          3'd4: if (bus_wdata == 8'h1A) m_mctl = 8'h9A;
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          3'd0: if (bank) e_rdata = 0; else begin
            e_rdata = rx_avail ? rxq[0] : 8'h00;
            if (rx_avail) void'(rxq.pop_front());
            m_rxs = 0;
            if (m_ien[0]) rx_dl = cyc + N;
          end
          3'd1: e_rdata = bank ? 8'h00 : m_ien;
          3'd2: if (pre_rx) e_rdata = 8'h04;
                else if (pre_tx) begin e_rdata = 8'h02; m_txs = 0; end
                else e_rdata = 8'h01;
          3'd3: e_rdata = m_lctl;
          3'd4: e_rdata = m_mctl;
          3'd5: e_rdata = 8'h60 | {7'd0, rx_avail};
          default: e_rdata = 8'h00;
        endcase
      end
      prev_avail = rx_avail;
    end
    cyc++;
    started = 1;
  end

  // every-cycle comparison against the model, quarter cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (started && !done) begin
        chk({cur_req, " rdata"}, bus_rdata, e_rdata);
        chk({cur_req, " irq R13"}, irq, (m_rxs || m_txs) ? 1 : 0);
        chk({cur_req, " push R5"}, tx_push, e_push);
        if (e_push) chk({cur_req, " txbyte R5"}, tx_byte, e_txb);
        chk({cur_req, " pop R4"}, rx_pop,
            (!rst && bus_rd && bus_addr == 3'd0 && !m_lctl[7] && rx_avail) ? 1 : 0);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string req, int exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(3'd2, "R1 idt", 8'h01);
    rd(3'd5, "R1 lsts", 8'h60);

    cur_req = "R2";
    wr(3'd3, 8'h03); rd(3'd3, "R2 lctl", 8'h03);
    wr(3'd7, 8'h55); rd(3'd7, "R2 scr", 8'h00);
    rd(3'd6, "R2 msts", 8'h00);
    wr(3'd2, 8'hC7); rd(3'd2, "R2 fcr ignored", 8'h01);

    cur_req = "R12";
    wr(3'd4, 8'h11); rd(3'd4, "R12 other", 8'h00);
    wr(3'd4, 8'h1A); rd(3'd4, "R12 key", 8'h9A);
    wr(3'd4, 8'h00); rd(3'd4, "R12 hold", 8'h9A);

    cur_req = "R5";
    wr(3'd0, 8'hA5); idle(20);
    chk("R5 no irq disabled", irq, 0);

    cur_req = "R9";
    wr(3'd1, 8'h02);
    chk("R9 immediate", irq, 1);
    cur_req = "R8";
    rd(3'd2, "R8 tx id", 8'h02);
    rd(3'd2, "R8 tx cleared", 8'h01);
    cur_req = "R9";
    wr(3'd1, 8'h02);
    chk("R9 delayed", irq, 0);
    idle(15);
    chk("R9 posted", irq, 1);
    rd(3'd2, "R9 id", 8'h02);

    cur_req = "R6";
    wr(3'd0, 8'h11); idle(5); wr(3'd0, 8'h22);
    idle(8);
    chk("R6 restarted", irq, 0);
    idle(6);
    chk("R6 expired", irq, 1);
    rd(3'd2, "R6 id", 8'h02);

    cur_req = "R10";
    wr(3'd0, 8'h33); idle(3); wr(3'd1, 8'h00); idle(15);
    chk("R10 cancelled", irq, 0);

    cur_req = "R11";
    wr(3'd1, 8'h01);
    @(negedge clk); push_rx(8'h5A);
    idle(5);
    chk("R11 early", irq, 0);
    idle(10);
    chk("R11 posted", irq, 1);
    rd(3'd2, "R8 rx id", 8'h04);
    cur_req = "R4";
    rd(3'd0, "R4 byte", 8'h5A);
    chk("R4 rx cleared", irq, 0);
    @(negedge clk); push_rx(8'h61); push_rx(8'h62);
    idle(15);
    chk("R4 posted", irq, 1);
    rd(3'd0, "R4 byte1", 8'h61);
    chk("R4 clear", irq, 0);
    idle(14);
    chk("R4 restart posts", irq, 1);
    rd(3'd0, "R4 byte2", 8'h62);
    cur_req = "R7";
    idle(14);
    chk("R7 empty no post", irq, 0);
    cur_req = "R4";
    rd(3'd0, "R4 empty read", 8'h00);

    cur_req = "R8";
    wr(3'd1, 8'h03);
    @(negedge clk); push_rx(8'h70);
    idle(15);
    rd(3'd2, "R8 rx first", 8'h04);
    rd(3'd2, "R8 rx keeps tx", 8'h04);
    rd(3'd0, "R8 data", 8'h70);
    rd(3'd2, "R8 tx next", 8'h02);
    rd(3'd2, "R8 none", 8'h01);

    cur_req = "R3";
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h83);
    @(negedge clk); push_rx(8'h44);
    wr(3'd0, 8'h77);
    wr(3'd1, 8'h03);
    rd(3'd0, "R3 banked data", 8'h00);
    rd(3'd1, "R3 banked ien", 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd1, "R3 ien kept", 8'h00);
    rd(3'd0, "R3 byte kept", 8'h44);
    idle(4);
    finish_run();
  end
endmodule